// File: doc/BRIEF.md
# Shared-Bus Parameter and Working Store Controller

This block sits behind a single address bus, data bus and pair of request lines driven by a network sequencer. It serves two stores from that bus. The first is a constant store that holds weights, biases and activation-table entries, which stay fixed while the network runs. The second is a working store that holds input values and intermediate neuron results, which change as the computation proceeds. On a read, the top address bit picks the store that answers. A write always lands in the working store. An attempt to write the constant region is refused.

Every access is atomic and completes in one cycle. A request is sampled on a clock edge. On the following cycle the block raises a one-cycle acknowledge, and for a read the data is on the read half of the data bus at that time. Read and write requests must not overlap. If both request lines are raised in the same cycle, the request is rejected. The data bus is modelled as its two directions, a write-data input and a registered read-data output. Widths and depths are parameters, and the constant store is filled from an arithmetic rule chosen by parameters.

Top module: `nnps_store`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ack`, `bad_req` and `rd_data` are 0, and every working-store word reads back as 0 until it is written.
- R2: A read with `addr[AW-1]` = 0 returns constant word i = `addr[AW-2:0]`, with value (i*CONST_MULT + CONST_ADD) mod 2^DW, on `rd_data` in the cycle after the request, together with `ack` = 1.
- R3: A read with `addr[AW-1]` = 1 returns the working-store word at index `addr[AW-2:0]` on `rd_data` in the cycle after the request, together with `ack` = 1.
- R4: A write with `addr[AW-1]` = 1 stores `wr_data` at index `addr[AW-2:0]` and raises `ack` for one cycle. A read in the very next cycle sees the new value.
- R5: A write with `addr[AW-1]` = 0 changes no store. In the next cycle `bad_req` is 1 and `ack` is 0. A later read of the same constant word, or of the working word with the same low index, returns its earlier value.
- R6: When `rd_req` and `wr_req` are both 1, neither access is performed. The next cycle shows `bad_req` = 1 and `ack` = 0, `rd_data` is unchanged, and no working word changes.
- R7: `rd_data` changes only in the cycle after an accepted read. Writes, rejected requests and idle cycles leave it holding the last value read.
- R8: With no request, the next cycle shows `ack` = 0 and `bad_req` = 0. `ack` and `bad_req` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request for this cycle |
| wr_req | input | 1 | Write request for this cycle |
| addr | input | AW | Shared address; the top bit selects the region (0 constant, 1 working) |
| wr_data | input | DW | Write half of the shared data bus |
| rd_data | output | DW | Read half of the shared data bus, registered |
| ack | output | 1 | One-cycle pulse after an accepted access |
| bad_req | output | 1 | One-cycle pulse after a rejected request |

## Verification
Two of the block's functions can fall into the same cycle. The first is a read and a write raised together. The second is a write aimed at the constant region, which competes with a working-store write at the same low index. Random stimulus raises both request lines together about one time in ten and folds addresses onto a few low indices, so that rejected writes and accepted accesses hit the same words again and again. Each cycle is judged against a bench model of both stores and the held read value: a rejected cycle must give `bad_req` without `ack`, must leave `rd_data` unchanged, and must leave a later read of either store exactly as the model predicts.

// File: rtl/nnps_pkg.sv
package nnps_pkg;
   typedef enum logic [2:0] {
      OP_IDLE,
      OP_RD_CONST,
      OP_RD_WORK,
      OP_WR_WORK,
      OP_REJECT
   } op_e;

   // Constant-store fill rule: word i = (i*mult + add), truncated by caller
   function automatic logic [31:0] const_word(input int unsigned idx,
                                              input logic [31:0] mult,
                                              input logic [31:0] add);
      logic [31:0] prod;
      prod = idx * mult;
      return prod + add;
   endfunction
endpackage

// File: rtl/nnps_decode.sv
module nnps_decode #(
   parameter int AW = 7
) (
   input  logic          rd_req,
   input  logic          wr_req,
   input  logic [AW-1:0] addr,
   output nnps_pkg::op_e op
);
   import nnps_pkg::*;

   logic work_region;
   assign work_region = addr[AW-1];

   always_comb begin
      if (rd_req && wr_req)      op = OP_REJECT;
      else if (wr_req)           op = work_region ? OP_WR_WORK : OP_REJECT;
      else if (rd_req)           op = work_region ? OP_RD_WORK : OP_RD_CONST;
      else                       op = OP_IDLE;
   end
endmodule

// File: rtl/nnps_const_rom.sv
module nnps_const_rom #(
   parameter int          DW         = 16,
   parameter int          IW         = 6,
   parameter logic [31:0] CONST_MULT = 32'h0000_9E37,
   parameter logic [31:0] CONST_ADD  = 32'h0000_0155
) (
   input  logic [IW-1:0] idx,
   output logic [DW-1:0] word
);
   localparam int DEPTH = 1 << IW;

   logic [DW-1:0] table_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      localparam logic [31:0] FULL = nnps_pkg::const_word(i, CONST_MULT, CONST_ADD);
      assign table_q[i] = FULL[DW-1:0];
   end

   assign word = table_q[idx];
endmodule

// File: rtl/nnps_work_ram.sv
module nnps_work_ram #(
   parameter int DW        = 16,
   parameter int IW        = 6,
   parameter bit RAM_CLEAR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rword
);
   localparam int DEPTH = 1 << IW;

   logic [DW-1:0] mem_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic hit;
      assign hit = we && (idx == IW'(i));
      if (RAM_CLEAR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   mem_q[i] <= '0;
            else if (hit) mem_q[i] <= wdata;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (hit) mem_q[i] <= wdata;
         end
      end
   end

   assign rword = mem_q[idx];
endmodule

// File: rtl/nnps_store.sv
module nnps_store #(
   parameter int          AW         = 7,
   parameter int          DW         = 16,
   parameter logic [31:0] CONST_MULT = 32'h0000_9E37,
   parameter logic [31:0] CONST_ADD  = 32'h0000_0155,
   parameter bit          RAM_CLEAR  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  logic          wr_req,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   output logic          ack,
   output logic          bad_req
);
   import nnps_pkg::*;

   localparam int IW = AW - 1;

   if (AW < 2 || AW > 13) begin : g_bad_aw
      $error("nnps_store: AW must lie in 2..13");
   end
   if (DW < 1 || DW > 32) begin : g_bad_dw
      $error("nnps_store: DW must lie in 1..32");
   end

   op_e           op;
   logic [IW-1:0] idx;
   logic [DW-1:0] const_q;
   logic [DW-1:0] work_q;

   assign idx = addr[IW-1:0];

   nnps_decode #(.AW(AW)) u_decode (
      .rd_req (rd_req),
      .wr_req (wr_req),
      .addr   (addr),
      .op     (op)
   );

   nnps_const_rom #(
      .DW(DW), .IW(IW), .CONST_MULT(CONST_MULT), .CONST_ADD(CONST_ADD)
   ) u_rom (
      .idx  (idx),
      .word (const_q)
   );

   nnps_work_ram #(.DW(DW), .IW(IW), .RAM_CLEAR(RAM_CLEAR)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (op == OP_WR_WORK),
      .idx   (idx),
      .wdata (wr_data),
      .rword (work_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         ack     <= 1'b0;
         bad_req <= 1'b0;
      end else begin
         ack     <= (op == OP_RD_CONST) || (op == OP_RD_WORK) || (op == OP_WR_WORK);
         bad_req <= (op == OP_REJECT);
         if (op == OP_RD_CONST)     rd_data <= const_q;
         else if (op == OP_RD_WORK) rd_data <= work_q;
      end
   end
endmodule

// File: rtl/nnps_store_chk.sv
module nnps_store_chk #(
   parameter int          AW         = 7,
   parameter int          DW         = 16,
   parameter logic [31:0] CONST_MULT = 32'h0000_9E37,
   parameter logic [31:0] CONST_ADD  = 32'h0000_0155
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_req,
   input logic          wr_req,
   input logic [AW-1:0] addr,
   input logic [DW-1:0] rd_data,
   input logic          ack,
   input logic          bad_req
);
   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   function automatic logic [DW-1:0] exp_const(input logic [AW-1:0] a);
      logic [31:0] full;
      full = nnps_pkg::const_word(int'(a[AW-2:0]), CONST_MULT, CONST_ADD);
      return full[DW-1:0];
   endfunction

   // R8
   ack_bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack && bad_req));

   // R6
   dual_req_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && wr_req) |=> (bad_req && !ack));

   // R5
   const_write_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !rd_req && !addr[AW-1]) |=> (bad_req && !ack));

   // R2
   const_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !wr_req && !addr[AW-1]) |=> (ack && rd_data == exp_const($past(addr))));

   // R7
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !(rd_req && !wr_req)) |=> $stable(rd_data));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_req && !wr_req) |=> (!ack && !bad_req));
endmodule

bind nnps_store nnps_store_chk #(
   .AW(AW), .DW(DW), .CONST_MULT(CONST_MULT), .CONST_ADD(CONST_ADD)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_req  (rd_req),
   .wr_req  (wr_req),
   .addr    (addr),
   .rd_data (rd_data),
   .ack     (ack),
   .bad_req (bad_req)
);

// File: tb/nnps_store_bench.sv
`timescale 1ns/1ps
module nnps_store_bench;
   localparam int          AW    = 7;
   localparam int          DW    = 16;
   localparam int          IW    = AW - 1;
   localparam int          DEPTH = 1 << IW;
   localparam logic [31:0] MULT  = 32'h0000_9E37;
   localparam logic [31:0] ADDV  = 32'h0000_0155;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_req = 1'b0, wr_req = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          ack, bad_req;

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;

   logic [DW-1:0] model_ram [DEPTH];
   logic [DW-1:0] model_rd;

   always #10 clk = ~clk;

   nnps_store #(.AW(AW), .DW(DW), .CONST_MULT(MULT), .CONST_ADD(ADDV)) u_nnps_store (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .ack(ack), .bad_req(bad_req)
   );

   function automatic logic [DW-1:0] const_exp(input int unsigned i);
      logic [31:0] v;
      v = i * MULT + ADDV;
      return v[DW-1:0];
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // one request, sampled 1 ns after the edge that accepts it
   task automatic access(input logic rd, input logic wr,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic e_ack, e_bad;
      string tag;
      rd_req = rd; wr_req = wr; addr = a; wr_data = d;
      e_ack = 1'b0; e_bad = 1'b0;
      if (rd && wr) begin
         tag = "R6"; e_bad = 1'b1;
      end else if (wr && !a[AW-1]) begin
         tag = "R5"; e_bad = 1'b1;
      end else if (wr) begin
         tag = "R4"; e_ack = 1'b1; model_ram[a[IW-1:0]] = d;
      end else if (rd && !a[AW-1]) begin
         tag = "R2"; e_ack = 1'b1; model_rd = const_exp(int'(a[IW-1:0]));
      end else if (rd) begin
         tag = "R3"; e_ack = 1'b1; model_rd = model_ram[a[IW-1:0]];
      end else begin
         tag = "R8";
      end
      @(posedge clk); #1;
      check(tag, "ack", 32'(ack), 32'(e_ack));
      check(tag, "bad_req", 32'(bad_req), 32'(e_bad));
      // R7: rd_data moves only after accepted reads
      check((rd && !wr) ? tag : "R7", "rd_data", 32'(rd_data), 32'(model_rd));
      rd_req = 1'b0; wr_req = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd4242;
      void'($urandom(seed));
      for (int i = 0; i < DEPTH; i++) model_ram[i] = '0;
      model_rd = '0;

      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1", "ack in reset", 32'(ack), 0);
      check("R1", "bad_req in reset", 32'(bad_req), 0);
      check("R1", "rd_data in reset", 32'(rd_data), 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1", "ack after reset", 32'(ack), 0);
      check("R1", "rd_data after reset", 32'(rd_data), 0);

      // R1: working store cleared
      access(1'b1, 1'b0, {1'b1, 6'd5}, '0);
      access(1'b1, 1'b0, {1'b1, 6'd63}, '0);
      // R2: constant boundaries
      access(1'b1, 1'b0, {1'b0, 6'd0}, '0);
      access(1'b1, 1'b0, {1'b0, 6'd63}, '0);
      // R4: write then immediate read back
      access(1'b0, 1'b1, {1'b1, 6'd9}, 16'hBEEF);
      access(1'b1, 1'b0, {1'b1, 6'd9}, '0);
      // R5: write to constant region, same low index; then both stores read back
      access(1'b0, 1'b1, {1'b0, 6'd9}, 16'h1234);
      access(1'b1, 1'b0, {1'b0, 6'd9}, '0);
      access(1'b1, 1'b0, {1'b1, 6'd9}, '0);
      // R6: both requests together, then read back the target word
      access(1'b1, 1'b1, {1'b1, 6'd9}, 16'h5555);
      access(1'b1, 1'b1, {1'b0, 6'd3}, 16'h7777);
      access(1'b1, 1'b0, {1'b1, 6'd9}, '0);
      // R8: idle cycles
      access(1'b0, 1'b0, '0, '0);
      access(1'b0, 1'b0, '1, '1);

      // constrained random mix with folded indices
      for (int n = 0; n < 3000; n++) begin
         int unsigned kind;
         logic [AW-1:0] a;
         kind = $urandom_range(0, 99);
         a = {1'($urandom), IW'($urandom_range(0, 7))};
         if ((n % 4) == 0) a = AW'($urandom);
         if (kind < 40)      access(1'b1, 1'b0, a, '0);
         else if (kind < 80) access(1'b0, 1'b1, a, DW'($urandom));
         else if (kind < 90) access(1'b1, 1'b1, a, DW'($urandom));
         else                access(1'b0, 1'b0, a, DW'($urandom));
      end

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule